// File: doc/BRIEF.md
# Dual-Channel Third-Order Decimating Filter

This block turns two 1-bit delta-sigma bitstreams into 24-bit samples. Both bitstreams come out of one Manchester-coded link. A shared bit-valid strobe from the upstream decoder marks each new input bit. Each channel runs through its own third-order cascaded integrator-comb decimator. A 2-bit run-time code selects the decimation ratio: 32, 64, 128 or 256 input bits per output sample. The raw filter sum is shifted up by the ratio-dependent amount needed to fill 24 bits, and it saturates at full scale.

Results are published to both channels at once. Each result is read as a 16-bit upper word and an 8-bit lower word through a simple registered read port. A buffer-full flag shows that a fresh pair of samples is waiting. Reading the second channel's upper word clears that flag. A new pair that lands before the read raises a sticky overrun flag. Nothing is published while the decoder reports loss of synchronization. The first outputs after any restart are also held back, so that software only ever sees settled samples. A restart happens when the ratio code changes or when enable drops.

Top module: `sinc3_dual_decim`

## Requirements
- R1: Ratio code 0, 1, 2 and 3 make one output per 32, 64, 128 and 256 input strobes. With a strobe every cycle, successive publications are exactly that many cycles apart.
- R2: A constant all-ones input settles to 0xFFFFFF (saturated full scale), and a constant all-zeros input settles to 0x000000, at every ratio.
- R3: A periodic input whose period divides the ratio and whose ones-density is d settles to d·2^24. For example, 1010 gives 0x800000, 1000 gives 0x400000 and 1110 gives 0xC00000.
- R4: Read addresses map as follows. 0 is the channel A (bit_a) upper word, result bits 23:8. 1 is the channel A lower word, result bits 7:0 in rd_data[7:0], with rd_data[15:8] zero. 2 and 3 are the same two words for channel B (bit_b). 4 is status, with bit 0 buf_full and bit 1 overrun. All other addresses read zero. rd_data changes on the cycle after rd_en.
- R5: buf_full rises only when a new sample pair is published. A read of address 2 clears it, and reads of any other address leave it set.
- R6: Publishing while buf_full is still set raises overrun. Overrun stays set through reads, including the read of address 2.
- R7: No sample is published while sync_ok is low. The filters keep running, so once sync_ok rises the next output is published.
- R8: After enable rises or the ratio code changes, the first four decimated outputs are discarded. The first published value is fully settled.
- R9: While enable is low, buf_full and overrun are cleared, and the filter state and decimation counter are held at zero. The last published results remain readable.
- R10: After reset, buf_full and overrun are low and every result word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; low restarts the filters and clears the flags |
| osr_sel | input | 2 | Decimation ratio code (0:32, 1:64, 2:128, 3:256) |
| sync_ok | input | 1 | Decoder synchronization indication; gates publication |
| bit_valid | input | 1 | Strobe marking a new decoded bit on both channels |
| bit_a | input | 1 | Channel A modulator bit |
| bit_b | input | 1 | Channel B modulator bit |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Registered read data |
| buf_full | output | 1 | Fresh sample pair waiting |
| overrun | output | 1 | Sticky flag: a pair was overwritten before being read |

## Verification
The bench builds the block with its default warm-up count of four and the package widths, which span ratios 32 through 256. At those values even the largest ratio settles within about 1300 cycles. Every ratio code can therefore be driven to settled, exactly predictable values for periodic patterns whose period divides the ratio. Publication intervals are short enough to measure cycle-exactly. The warm-up count is small enough that the silent window after a restart can be checked for the absence of publication before the first settled output appears.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    localparam int ORDER        = 3;
    localparam int OSR_CODE_W   = 2;
    localparam int OSR_MIN_LOG2 = 5;
    localparam int OSR_MAX_LOG2 = OSR_MIN_LOG2 + (1 << OSR_CODE_W) - 1;
    localparam int ACC_W        = 1 + ORDER * OSR_MAX_LOG2;
    localparam int RES_W        = ORDER * OSR_MAX_LOG2;
    localparam int HI_W         = 16;
    localparam int LO_W         = RES_W - HI_W;
    localparam int DATA_W       = HI_W;
    localparam int NUM_CH       = 2;
    localparam int ADDR_W       = 3;
    localparam int CNT_W        = OSR_MAX_LOG2;

    typedef logic [OSR_CODE_W-1:0] osr_code_t;
    typedef logic [ACC_W-1:0]      acc_t;
    typedef logic [RES_W-1:0]      res_t;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } res_word_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_A_HI = 3'd0,
        RA_A_LO = 3'd1,
        RA_B_HI = 3'd2,
        RA_B_LO = 3'd3,
        RA_STAT = 3'd4
    } reg_addr_e;

    // Terminal count of the decimation counter for a ratio code.
    function automatic logic [CNT_W-1:0] osr_last(input osr_code_t code);
        logic [CNT_W-1:0] m;
        m = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i < OSR_MIN_LOG2 + int'(code)) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Bring a raw sum up to full result width, saturating at full scale.
    function automatic res_word_t scale_result(input acc_t raw, input osr_code_t code);
        acc_t s;
        int   sh;
        sh = ORDER * (OSR_MAX_LOG2 - OSR_MIN_LOG2 - int'(code));
        s  = raw << sh;
        return s[ACC_W-1] ? res_word_t'({RES_W{1'b1}}) : res_word_t'(s[RES_W-1:0]);
    endfunction

endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
    import sinc3_pkg::*;
#(
    parameter int WARMUP_OUTS = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  osr_code_t osr_sel,
    input  logic      bit_valid,
    output logic      clr,
    output logic      strobe,
    output logic      tick,
    output logic      pub,
    output osr_code_t osr_act
);
    localparam int WARM_W = $clog2(WARMUP_OUTS + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [WARM_W-1:0] warm_q;
    logic              tick_q;
    logic              pub_q;
    osr_code_t         osr_q;

    logic restart;
    logic at_last;
    logic warm_done;

    assign restart   = !enable || (osr_sel != osr_q);
    assign at_last   = (cnt_q == osr_last(osr_q));
    assign warm_done = (warm_q == WARM_W'(WARMUP_OUTS));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            warm_q <= '0;
            tick_q <= 1'b0;
            pub_q  <= 1'b0;
            osr_q  <= '0;
        end else if (restart) begin
            cnt_q  <= '0;
            warm_q <= '0;
            tick_q <= 1'b0;
            pub_q  <= 1'b0;
            osr_q  <= osr_sel;
        end else begin
            tick_q <= bit_valid && at_last;
            if (bit_valid) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
            pub_q <= tick_q && warm_done;
            if (tick_q && !warm_done) warm_q <= warm_q + 1'b1;
        end
    end

    assign clr     = rst || restart;
    assign strobe  = bit_valid && !restart;
    assign tick    = tick_q;
    assign pub     = pub_q;
    assign osr_act = osr_q;

endmodule

// File: rtl/sinc3_chan.sv
module sinc3_chan
    import sinc3_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic strobe,
    input  logic bit_in,
    input  logic tick,
    output acc_t result
);
    acc_t integ_q [ORDER];
    acc_t dly_q   [ORDER];
    acc_t comb_in [ORDER];
    acc_t comb_out;

    // Comb chain: each stage subtracts its own delayed input.
    always_comb begin
        acc_t v;
        v = integ_q[ORDER-1];
        for (int k = 0; k < ORDER; k++) begin
            comb_in[k] = v;
            v = v - dly_q[k];
        end
        comb_out = v;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            for (int k = 0; k < ORDER; k++) begin
                integ_q[k] <= '0;
                dly_q[k]   <= '0;
            end
            result <= '0;
        end else begin
            if (strobe) begin
                integ_q[0] <= integ_q[0] + {{(ACC_W-1){1'b0}}, bit_in};
                for (int k = 1; k < ORDER; k++) begin
                    integ_q[k] <= integ_q[k] + integ_q[k-1];
                end
            end
            if (tick) begin
                for (int k = 0; k < ORDER; k++) begin
                    dly_q[k] <= comb_in[k];
                end
                result <= comb_out;
            end
        end
    end

endmodule

// File: rtl/sinc3_regs.sv
module sinc3_regs
    import sinc3_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          enable,
    input  logic                          sync_ok,
    input  logic                          pub,
    input  osr_code_t                     osr_act,
    input  logic [NUM_CH-1:0][ACC_W-1:0]  raw,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          buf_full,
    output logic                          overrun
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    res_word_t         scaled [NUM_CH];
    res_word_t         held_q [NUM_CH];
    logic              full_q;
    logic              ovr_q;
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] rd_next;
    logic              do_pub;
    logic              clr_rd;
    logic [CH_W-1:0]   ch_idx;
    logic              in_range;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_scale
        assign scaled[g] = scale_result(raw[g], osr_act);
    end

    assign do_pub   = pub && sync_ok && enable;
    assign clr_rd   = rd_en && (rd_addr == RA_B_HI);
    assign ch_idx   = rd_addr[CH_W:1];
    assign in_range = ({1'b0, rd_addr[ADDR_W-1:1]} < ADDR_W'(NUM_CH));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CH; c++) held_q[c] <= '0;
        end else if (do_pub) begin
            for (int c = 0; c < NUM_CH; c++) held_q[c] <= scaled[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else if (do_pub) begin
            full_q <= 1'b1;
            if (full_q && !clr_rd) ovr_q <= 1'b1;
        end else if (clr_rd) begin
            full_q <= 1'b0;
        end
    end

    always_comb begin
        res_word_t sel;
        sel     = held_q[ch_idx];
        rd_next = '0;
        if (rd_addr == RA_STAT) begin
            rd_next = {{(DATA_W-2){1'b0}}, ovr_q, full_q};
        end else if (in_range) begin
            rd_next = rd_addr[0] ? DATA_W'(sel.lo) : sel.hi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_en) rd_q <= rd_next;
    end

    assign rd_data  = rd_q;
    assign buf_full = full_q;
    assign overrun  = ovr_q;

endmodule

// File: rtl/sinc3_dual_decim.sv
module sinc3_dual_decim
    import sinc3_pkg::*;
#(
    parameter int WARMUP_OUTS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic [OSR_CODE_W-1:0] osr_sel,
    input  logic                  sync_ok,
    input  logic                  bit_valid,
    input  logic                  bit_a,
    input  logic                  bit_b,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  buf_full,
    output logic                  overrun
);
    logic                         clr_w;
    logic                         strobe_w;
    logic                         tick_w;
    logic                         pub_w;
    osr_code_t                    osr_w;
    logic [NUM_CH-1:0]            bits_w;
    logic [NUM_CH-1:0][ACC_W-1:0] raw_w;

    assign bits_w = {bit_b, bit_a};

    sinc3_ctrl #(.WARMUP_OUTS(WARMUP_OUTS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .osr_sel   (osr_sel),
        .bit_valid (bit_valid),
        .clr       (clr_w),
        .strobe    (strobe_w),
        .tick      (tick_w),
        .pub       (pub_w),
        .osr_act   (osr_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        sinc3_chan u_chan (
            .clk    (clk),
            .clr    (clr_w),
            .strobe (strobe_w),
            .bit_in (bits_w[g]),
            .tick   (tick_w),
            .result (raw_w[g])
        );
    end

    sinc3_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .sync_ok  (sync_ok),
        .pub      (pub_w),
        .osr_act  (osr_w),
        .raw      (raw_w),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .buf_full (buf_full),
        .overrun  (overrun)
    );

endmodule

// File: rtl/sinc3_dual_decim_chk.sv
module sinc3_dual_decim_chk (
    input logic        clk,
    input logic        rst,
    input logic        enable,
    input logic        sync_ok,
    input logic        rd_en,
    input logic [2:0]  rd_addr,
    input logic [15:0] rd_data,
    input logic        buf_full,
    input logic        overrun,
    input logic        pub
);
    // R5: reading the second channel's upper word clears the flag
    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (buf_full && enable && rd_en && rd_addr == 3'd2 && !pub) |=> !buf_full);

    // R5: the flag rises only after a publication request
    a_r5_set_on_pub: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_full) |-> $past(pub));

    // R7: no publication without decoder synchronization
    a_r7_needs_sync: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_full) |-> $past(sync_ok));

    // R6: overrun is sticky while running
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun && enable) |=> overrun);

    // R6: overrun only arises on top of an unread pair
    a_r6_needs_full: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(buf_full));

    // R9: disabling clears both flags
    a_r9_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!buf_full && !overrun));

    // R4: lower-word reads carry zeros in the upper byte
    a_r4_lo_upper_zero: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && ($past(rd_addr) == 3'd1 || $past(rd_addr) == 3'd3))
        |-> (rd_data[15:8] == 8'h00));

endmodule

bind sinc3_dual_decim sinc3_dual_decim_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .sync_ok  (sync_ok),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .buf_full (buf_full),
    .overrun  (overrun),
    .pub      (pub_w)
);

// File: tb/sinc3_dual_decim_test.sv
`timescale 1ns/1ps
module sinc3_dual_decim_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic [1:0]  osr_sel;
    logic        sync_ok;
    logic        bit_valid;
    logic        bit_a;
    logic        bit_b;
    logic        rd_en;
    logic [2:0]  rd_addr;
    logic [15:0] rd_data;
    logic        buf_full;
    logic        overrun;

    logic [3:0]  pat_a;
    logic [3:0]  pat_b;
    logic        stream_on;
    int          phase;
    int          n_chk;
    int          n_fail;

    always #4 clk = ~clk;

    sinc3_dual_decim uut (
        .clk(clk), .rst(rst), .enable(enable), .osr_sel(osr_sel),
        .sync_ok(sync_ok), .bit_valid(bit_valid), .bit_a(bit_a), .bit_b(bit_b),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .buf_full(buf_full), .overrun(overrun)
    );

    // Bit source: one strobe per cycle while streaming, 4-bit periodic patterns.
    initial begin
        bit_valid = 1'b0; bit_a = 1'b0; bit_b = 1'b0; phase = 0;
        forever begin
            @(negedge clk);
            if (stream_on) begin
                bit_valid = 1'b1;
                bit_a = pat_a[phase];
                bit_b = pat_b[phase];
                phase = (phase + 1) % 4;
            end else begin
                bit_valid = 1'b0;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] addr, output logic [15:0] data);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = addr;
        @(negedge clk);
        data = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic wait_full(input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (buf_full) begin seen = 1'b1; break; end
        end
    endtask

    task automatic restart(input logic [1:0] code, input logic [3:0] pa, input logic [3:0] pb);
        @(negedge clk);
        enable = 1'b0; osr_sel = code; pat_a = pa; pat_b = pb; stream_on = 1'b1;
        @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic read_pair(input string req, input logic [23:0] ea, input logic [23:0] eb);
        logic [15:0] d;
        rd(3'd0, d); check({req, " A hi"}, d, ea[23:8]);
        rd(3'd1, d); check({req, " A lo"}, d, {8'h00, ea[7:0]});
        rd(3'd3, d); check({req, " B lo"}, d, {8'h00, eb[7:0]});
        rd(3'd2, d); check({req, " B hi"}, d, eb[23:8]);
    endtask

    // R10: reset state
    task automatic t_reset();
        logic [15:0] d;
        check("R10 buf_full", buf_full, 0);
        check("R10 overrun", overrun, 0);
        rd(3'd0, d); check("R10 A hi", d, 0);
        rd(3'd3, d); check("R10 B lo", d, 0);
        rd(3'd4, d); check("R10 status", d, 0);
    endtask

    // R2/R3/R4: settled values for a ratio and pattern pair
    task automatic t_values(input string req, input logic [1:0] code,
                            input logic [3:0] pa, input logic [3:0] pb,
                            input logic [23:0] ea, input logic [23:0] eb);
        bit seen;
        int osr;
        logic [15:0] d;
        osr = 32 << code;
        restart(code, pa, pb);
        wait_full(6 * osr + 20, seen);
        check({req, " published"}, seen, 1);
        rd(3'd2, d);
        wait_full(osr + 8, seen);
        read_pair(req, ea, eb);
    endtask

    // R1: publication interval in cycles with a strobe every cycle
    task automatic t_interval(input logic [1:0] code);
        bit seen;
        int cnt;
        int osr;
        osr = 32 << code;
        restart(code, 4'hF, 4'h0);
        wait_full(6 * osr + 20, seen);
        rd_en = 1'b1; rd_addr = 3'd2;
        cnt = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) rd_en = 1'b0;
            if (cnt > 1 && buf_full) break;
        end
        check($sformatf("R1 interval code %0d", code), cnt, osr);
    endtask

    // R8: warm-up outputs are suppressed, first published is settled
    task automatic t_warmup();
        bit seen;
        restart(2'd0, 4'hF, 4'h5);
        for (int i = 0; i < 4 * 32 + 8; i++) @(negedge clk);
        check("R8 silent during warm-up", buf_full, 0);
        wait_full(80, seen);
        check("R8 first publication", seen, 1);
        read_pair("R8", 24'hFFFFFF, 24'h800000);
    endtask

    // R7: no publication without sync
    task automatic t_nosync();
        bit seen;
        bit ever;
        sync_ok = 1'b0;
        restart(2'd0, 4'h1, 4'hF);
        ever = 1'b0;
        for (int i = 0; i < 8 * 32; i++) begin
            @(negedge clk);
            if (buf_full) ever = 1'b1;
        end
        check("R7 no flag unsynced", ever, 0);
        sync_ok = 1'b1;
        wait_full(40, seen);
        check("R7 publishes after sync", seen, 1);
        read_pair("R7", 24'h400000, 24'hFFFFFF);
    endtask

    // R5: only a read of address 2 clears buf_full
    task automatic t_flag();
        bit seen;
        logic [15:0] d;
        restart(2'd0, 4'h3, 4'h0);
        wait_full(6 * 32 + 20, seen);
        rd(3'd2, d);
        wait_full(40, seen);
        check("R5 set on publish", seen, 1);
        rd(3'd0, d); rd(3'd1, d); rd(3'd3, d); rd(3'd4, d);
        check("R5 status shows full", d, 16'h0001);
        check("R5 other reads keep flag", buf_full, 1);
        rd(3'd2, d);
        check("R5 addr 2 read clears", buf_full, 0);
        rd(3'd5, d); check("R4 unused addr 5", d, 0);
        rd(3'd7, d); check("R4 unused addr 7", d, 0);
    endtask

    // R6/R9: overrun is sticky, disable clears flags and keeps results
    task automatic t_overrun();
        bit seen;
        logic [15:0] d;
        restart(2'd0, 4'hF, 4'h0);
        wait_full(6 * 32 + 20, seen);
        rd(3'd2, d);
        wait_full(40, seen);
        for (int i = 0; i < 40; i++) @(negedge clk);
        check("R6 overrun raised", overrun, 1);
        rd(3'd4, d);
        check("R6 status both flags", d, 16'h0003);
        rd(3'd2, d);
        check("R6 overrun survives read", overrun, 1);
        check("R5 cleared after read", buf_full, 0);
        enable = 1'b0;
        @(negedge clk);
        check("R9 flag cleared", buf_full, 0);
        check("R9 overrun cleared", overrun, 0);
        rd(3'd0, d);
        check("R9 result retained", d, 16'hFFFF);
        enable = 1'b1;
    endtask

    initial begin
        rst = 1'b1; enable = 1'b0; osr_sel = 2'd0; sync_ok = 1'b1;
        rd_en = 1'b0; rd_addr = 3'd0; pat_a = 4'h0; pat_b = 4'h0; stream_on = 1'b0;
        n_chk = 0; n_fail = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_values("R2 ones/zeros r32",  2'd0, 4'hF, 4'h0, 24'hFFFFFF, 24'h000000);
        t_values("R3 half/quarter r64", 2'd1, 4'h5, 4'h1, 24'h800000, 24'h400000);
        t_values("R3 3q/ones r128",    2'd2, 4'h7, 4'hF, 24'hC00000, 24'hFFFFFF);
        t_values("R2 zeros/half r256", 2'd3, 4'h0, 4'hA, 24'h000000, 24'h800000);
        t_interval(2'd0);
        t_interval(2'd1);
        t_interval(2'd2);
        t_warmup();
        t_nosync();
        t_flag();
        t_overrun();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule